// File: doc/BRIEF.md
# H-Bridge Gate Command Sequencer with Turn-On Dead-Time

This block converts a small set of control bits into the four gate commands of a full bridge: the low and high switch of leg A and of leg B. It takes a direction bit from an upstream comparator, a bit that permits or blocks high-side switching, a hard disable and an undervoltage flag, and decodes them into diagonal-pair requests. Each leg's low and high requests are mutually exclusive. A supervisor refresh flag can override the decode and request both low switches, so that the bootstrap capacitors are recharged.

Each of the four requests then passes through its own gate timer. Dropping a request switches the gate off at the next clock edge. Raising a request switches the gate on only after it has been held for a programmable number of clock cycles, which inserts dead-time after the opposing switch of the same leg turns off. One 8-bit setting applies to both high-side switches and another applies to both low-side switches. The outputs are registered and drive the gate driver stage directly.

Top module: `hbridge_gate_sequencer`

## Requirements
- R1: While disableIn or underVolt is 1 at a clock edge, all four gate outputs are 0 after that edge, whatever the other inputs are.
- R2: With highEn=1 and dirIn=1 (not disabled, no refresh), the requests are aHigh and bLow on and aLow and bHigh off.
- R3: With highEn=1 and dirIn=0 (not disabled, no refresh), the requests are aLow and bHigh on and aHigh and bLow off.
- R4: With highEn=0 (not disabled, no refresh), both high-side outputs are off; bLow is requested when dirIn=1 and aLow when dirIn=0.
- R5: A gate whose request is withdrawn is 0 after the first clock edge at which the request is absent. No delay is added to turn-off.
- R6: A requested gate turns on after the (d+1)-th consecutive clock edge at which its request is present. For aHigh and bHigh, d is hiDelay; for aLow and bLow, d is loDelay. d ranges from 0 to 255, and d=0 gives a single edge. A gate that is already on stays on while its request stays present.
- R7: aLow and aHigh are never 1 in the same cycle, and neither are bLow and bHigh.
- R8: If a request is withdrawn before its delay has elapsed, the pending turn-on is cancelled. A later request counts the full delay again from zero.
- R9: With refreshReq=1 and neither disableIn nor underVolt, aLow and bLow are requested and both high outputs are 0 after the edge. The low turn-ons still obey loDelay. Refresh takes priority over the R2 to R4 decode.
- R10: After reset, all four outputs are 0 and every pending delay is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirIn | input | 1 | Direction bit from the comparator |
| highEn | input | 1 | Permits high-side switching when 1 |
| disableIn | input | 1 | Forces all gates off when 1 |
| underVolt | input | 1 | Supply undervoltage flag, forces all gates off |
| refreshReq | input | 1 | Supervisor bootstrap refresh, requests both low switches |
| hiDelay | input | 8 | Turn-on delay in cycles for both high-side gates |
| loDelay | input | 8 | Turn-on delay in cycles for both low-side gates |
| aLow | output | 1 | Leg A low-side gate command |
| aHigh | output | 1 | Leg A high-side gate command |
| bLow | output | 1 | Leg B low-side gate command |
| bHigh | output | 1 | Leg B high-side gate command |

## Verification
Directed runs walk the decode through each combination of the enable and direction bits, so that a swapped diagonal pair (R2, R3) can be told apart from a high-side enable that leaks into the lower switches (R4). They also cover disable and undervoltage asserted together with every other input, which separates a real forced-off state from the refresh override. Delay settings of 0, small values and 255 are each held across direction reversals to pin down the exact edge of turn-on and to show that turn-off is not delayed. A reversal placed in the middle of a count shows whether a pending turn-on is cancelled or wrongly carried over. A long seeded random run then mixes direction flips, enable toggles, brief disables, refresh pulses and delay changes, and compares every cycle against a per-gate hold-count model.

// File: rtl/hbdrv_pkg.sv
package hbdrv_pkg;

  localparam int NumGates = 4;

  // Vector view of the request struct: bit0 aLow, bit1 aHigh, bit2 bLow, bit3 bHigh
  localparam logic [NumGates-1:0] HighSideMask = 4'b1010;

  typedef struct packed {
    logic bHigh;
    logic bLow;
    logic aHigh;
    logic aLow;
  } gateReq_t;

endpackage

// File: rtl/hbdrv_ctrl.sv
module hbdrv_ctrl
  import hbdrv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dirIn,
  input  logic     highEn,
  input  logic     disableIn,
  input  logic     underVolt,
  input  logic     refreshReq,
  output gateReq_t gateReq
);

  logic forcedOff;
  assign forcedOff = disableIn || underVolt;

  always_comb begin
    gateReq = '0;
    if (forcedOff) begin
      gateReq = '0;
    end else if (refreshReq) begin
      gateReq.aLow = 1'b1;
      gateReq.bLow = 1'b1;
    end else begin
      gateReq.aHigh = highEn && dirIn;
      gateReq.bLow  = dirIn;
      gateReq.aLow  = !dirIn;
      gateReq.bHigh = highEn && !dirIn;
    end
  end

  // R2: enabled forward diagonal
  assert_diag_fwd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!forcedOff && !refreshReq && highEn && dirIn) |->
      (gateReq == gateReq_t'{bHigh: 1'b0, bLow: 1'b1, aHigh: 1'b1, aLow: 1'b0}));

  // R3: enabled reverse diagonal
  assert_diag_rev_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!forcedOff && !refreshReq && highEn && !dirIn) |->
      (gateReq == gateReq_t'{bHigh: 1'b1, bLow: 1'b0, aHigh: 1'b0, aLow: 1'b1}));

  // R4: high side blocked
  assert_high_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!forcedOff && !refreshReq && !highEn) |-> (!gateReq.aHigh && !gateReq.bHigh));

  // R7: requests of one leg never overlap
  assert_req_leg_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(gateReq.aLow && gateReq.aHigh) && !(gateReq.bLow && gateReq.bHigh));

endmodule

// File: rtl/hbdrv_timer_bank.sv
module hbdrv_timer_bank
  import hbdrv_pkg::*;
#(
  parameter int DelayW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateReq_t            gateReq,
  input  logic [DelayW-1:0]   hiDelay,
  input  logic [DelayW-1:0]   loDelay,
  output logic [NumGates-1:0] gateOut
);

  logic [NumGates-1:0] reqVec;
  assign reqVec = gateReq;

  for (genvar g = 0; g < NumGates; g++) begin : gGate
    localparam bit IsHigh = HighSideMask[g];

    logic [DelayW-1:0] dly;
    logic [DelayW-1:0] cntQ;
    logic              onQ;

    if (IsHigh) begin : gHi
      assign dly = hiDelay;
    end else begin : gLo
      assign dly = loDelay;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
        onQ  <= 1'b0;
      end else if (!reqVec[g]) begin
        cntQ <= '0;
        onQ  <= 1'b0;
      end else if (!onQ) begin
        if (cntQ >= dly) begin
          onQ <= 1'b1;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end

    assign gateOut[g] = onQ;

    // R5: withdrawn request turns the gate off at the next edge
    assert_turnoff_R5: assert property (@(posedge clk) disable iff (!rstN)
      !reqVec[g] |=> !onQ);

    // R6: a gate only turns on from a standing request
    assert_turnon_req_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(onQ) |-> $past(reqVec[g]));

    // R8: a withdrawn request discards its partial count
    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rstN)
      !reqVec[g] |=> (cntQ == '0));
  end

  // R7: never both switches of a leg
  assert_leg_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(gateOut[0] && gateOut[1]) && !(gateOut[2] && gateOut[3]));

endmodule

// File: rtl/hbridge_gate_sequencer.sv
module hbridge_gate_sequencer
  import hbdrv_pkg::*;
#(
  parameter int DelayW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirIn,
  input  logic              highEn,
  input  logic              disableIn,
  input  logic              underVolt,
  input  logic              refreshReq,
  input  logic [DelayW-1:0] hiDelay,
  input  logic [DelayW-1:0] loDelay,
  output logic              aLow,
  output logic              aHigh,
  output logic              bLow,
  output logic              bHigh
);

  gateReq_t            gateReq;
  logic [NumGates-1:0] gateOut;

  hbdrv_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dirIn      (dirIn),
    .highEn     (highEn),
    .disableIn  (disableIn),
    .underVolt  (underVolt),
    .refreshReq (refreshReq),
    .gateReq    (gateReq)
  );

  hbdrv_timer_bank #(.DelayW(DelayW)) u_timers (
    .clk     (clk),
    .rstN    (rstN),
    .gateReq (gateReq),
    .hiDelay (hiDelay),
    .loDelay (loDelay),
    .gateOut (gateOut)
  );

  assign aLow  = gateOut[0];
  assign aHigh = gateOut[1];
  assign bLow  = gateOut[2];
  assign bHigh = gateOut[3];

  // R1: disable or undervoltage forces everything off
  assert_forced_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (disableIn || underVolt) |=> !(aLow || aHigh || bLow || bHigh));

  // R9: refresh keeps both high switches off
  assert_refresh_R9: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !disableIn && !underVolt) |=> (!aHigh && !bHigh));

  // R10: nothing is driven in the first cycle after reset
  assert_reset_off_R10: assert property (@(posedge clk)
    !rstN |=> !(aLow || aHigh || bLow || bHigh));

endmodule

// File: tb/sim_hbridge_gate_sequencer.sv
`timescale 1ns/1ps
module sim_hbridge_gate_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirIn = 1'b0, highEn = 1'b0, disableIn = 1'b0, underVolt = 1'b0, refreshReq = 1'b0;
  logic [7:0] hiDelay = 8'd0, loDelay = 8'd0;
  logic aLow, aHigh, bLow, bHigh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int hold [4];
  bit expOn [4];

  always #2.5 clk = ~clk;

  hbridge_gate_sequencer u0 (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .highEn(highEn),
    .disableIn(disableIn), .underVolt(underVolt), .refreshReq(refreshReq),
    .hiDelay(hiDelay), .loDelay(loDelay),
    .aLow(aLow), .aHigh(aHigh), .bLow(bLow), .bHigh(bHigh)
  );

  // Expected requests, bit0 aLow, bit1 aHigh, bit2 bLow, bit3 bHigh
  function automatic logic [3:0] expReq(bit d, bit h, bit ds, bit uv, bit rf);
    if (ds || uv) return 4'b0000;          // R1
    if (rf) return 4'b0101;                // R9
    if (h) return d ? 4'b0110 : 4'b1001;   // R2 / R3
    return d ? 4'b0100 : 4'b0001;          // R4
  endfunction

  function automatic string autoTag(bit d, bit h, bit ds, bit uv, bit rf);
    if (ds || uv) return "R1";
    if (rf) return "R9";
    if (h) return d ? "R2" : "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {bH,bL,aH,aL} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive, advance the model one edge, check at the next negedge
  task automatic step(bit d, bit h, bit ds, bit uv, bit rf, logic [7:0] hd, logic [7:0] ld, string tag);
    logic [3:0] rq;
    logic [3:0] ev;
    logic [3:0] act;
    dirIn = d; highEn = h; disableIn = ds; underVolt = uv; refreshReq = rf;
    hiDelay = hd; loDelay = ld;
    rq = expReq(d, h, ds, uv, rf);
    for (int g = 0; g < 4; g++) begin
      int dl;
      dl = (g == 1 || g == 3) ? int'(hd) : int'(ld);
      if (rq[g]) begin
        if (hold[g] < 100000) hold[g]++;
        expOn[g] = expOn[g] || (hold[g] >= dl + 1);   // R6
      end else begin
        hold[g] = 0;                                  // R5 / R8
        expOn[g] = 1'b0;
      end
      ev[g] = expOn[g];
    end
    @(negedge clk);
    act = {bHigh, bLow, aHigh, aLow};
    check((tag == "") ? autoTag(d, h, ds, uv, rf) : tag, act, ev);
    check("R7", {1'b0, 1'b0, (bLow & bHigh), (aLow & aHigh)}, 4'b0000);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int g = 0; g < 4; g++) begin hold[g] = 0; expOn[g] = 1'b0; end
    repeat (4) @(negedge clk);
    // R10: reset state, with inputs that would otherwise request gates
    dirIn = 1'b1; highEn = 1'b1;
    @(negedge clk);
    check("R10", {bHigh, bLow, aHigh, aLow}, 4'b0000);
    dirIn = 1'b0; highEn = 1'b0;
    rstN = 1'b1;

    // R1: forced off under every other input
    repeat (3) step(1, 1, 1, 0, 0, 8'd4, 8'd2, "R1");
    repeat (3) step(0, 1, 0, 1, 1, 8'd4, 8'd2, "R1");
    step(1, 0, 1, 1, 1, 8'd4, 8'd2, "R1");

    // R6: turn-on timing from all-off, hi=4 lo=2
    repeat (8) step(1, 1, 0, 0, 0, 8'd4, 8'd2, "R6");
    repeat (3) step(1, 1, 0, 0, 0, 8'd4, 8'd2, "R2");
    // R5: reversal drops the old pair at once
    step(0, 1, 0, 0, 0, 8'd4, 8'd2, "R5");
    repeat (8) step(0, 1, 0, 0, 0, 8'd4, 8'd2, "R3");
    // R4: high side blocked, both directions
    repeat (6) step(1, 0, 0, 0, 0, 8'd4, 8'd2, "R4");
    repeat (6) step(0, 0, 0, 0, 0, 8'd4, 8'd2, "R4");

    // R8: cancel a pending turn-on and restart
    repeat (12) step(0, 1, 0, 0, 0, 8'd10, 8'd10, "R8");
    repeat (3) step(1, 1, 0, 0, 0, 8'd10, 8'd10, "R8");
    repeat (2) step(0, 1, 0, 0, 0, 8'd10, 8'd10, "R8");
    repeat (14) step(1, 1, 0, 0, 0, 8'd10, 8'd10, "R8");

    // R6: zero delay, flipping every cycle
    for (int i = 0; i < 8; i++) step(i[0], 1, 0, 0, 0, 8'd0, 8'd0, "R6");
    // R6: maximum delay
    repeat (260) step(0, 1, 0, 0, 0, 8'd255, 8'd255, "R6");
    repeat (260) step(1, 1, 0, 0, 0, 8'd255, 8'd255, "R6");

    // R9: refresh override, then refresh under disable
    repeat (10) step(1, 1, 0, 0, 1, 8'd3, 8'd5, "R9");
    repeat (3) step(1, 1, 1, 0, 1, 8'd3, 8'd5, "R1");
    repeat (8) step(0, 1, 0, 0, 1, 8'd3, 8'd5, "R9");

    // Random mix
    begin
      bit d = 1'b0, h = 1'b1;
      logic [7:0] hd = 8'd3, ld = 8'd2;
      for (int i = 0; i < 3000; i++) begin
        bit ds, uv, rf;
        if ($urandom % 6 == 0) d = ~d;
        if ($urandom % 12 == 0) h = ~h;
        if ($urandom % 50 == 0) hd = 8'($urandom % 8);
        if ($urandom % 50 == 0) ld = 8'($urandom % 8);
        ds = ($urandom % 40 == 0);
        uv = ($urandom % 45 == 0);
        rf = ($urandom % 25 == 0);
        step(d, h, ds, uv, rf, hd, ld, "");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule